// File: doc/BRIEF.md
# Double-Buffered Serial DAC Front End

This block is the digital side of a 16-bit serial-input digital-to-analog converter, rebuilt as synchronous logic running on a fast system clock. A host drives a slow serial clock, one data line and two active-low enables. The first enable steers incoming bits into an input shift register, most significant bit first. The second enable copies that register into an output latch. The output latch drives the converter switches with a straight-binary code. When both enables are low, every shifted bit goes through to the output at once. When both are high, nothing moves.

The serial clock, the data line and the enables all cross into the system domain through two-flop synchronizers. A rising-edge detector then turns each serial-clock pulse into a single-cycle action. The bit at the top of the input register is driven on a cascade output, so several identical blocks can share one bit stream. An active-low clear forces both stages to zero without waiting for a clock, and its release is resynchronized.

Top module: `ser_dac_front`

## Requirements
- R1: The input register holds 16 bits. The first bit shifted in ends up in bit 15. After 16 shift pulses and one latch pulse, `dac_code` equals the word that was sent.
- R2: With `shift_en_n` low and `load_en_n` high, each rising edge of `sclk` moves `sdin` into bit 0 and shifts the other bits one place up. `dac_code` stays unchanged. The effect is visible by the third rising edge of `clk` after `sclk` rises.
- R3: With `load_en_n` low and `shift_en_n` high, an `sclk` rising edge copies the input register into `dac_code` and leaves the input register unchanged.
- R4: With both enables low, an `sclk` rising edge shifts the input register. `dac_code` takes the value the register has after that shift, so each new bit shows at the output.
- R5: With both enables high, an `sclk` rising edge changes neither stage. Without an `sclk` rising edge, neither stage changes whatever the enables do.
- R6: While `clr_n` is low, `dac_code`, the input register and `sdout` are zero without waiting for a `clk` edge. `sclk` edges that occur while `clr_n` is low are ignored.
- R7: `sdout` equals bit 15 of the input register and changes only on a shift edge. When a second block takes its `sdin` from `sdout`, a latch pulse after 32 shared shift pulses leaves the first word sent in the downstream block and the second word in the upstream block.
- R8: Codes are straight binary and pass to `dac_code` unaltered: 0x0000 is zero scale, 0x8000 is half scale and 0xFFFF is full scale minus one LSB.
- R9: After `rst_n` is released, both stages are zero. An `sclk` that is already high at release does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every serial-side input |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| sclk | input | 1 | Serial clock; its rising edge triggers shift and latch actions |
| sdin | input | 1 | Serial data, most significant bit first |
| shift_en_n | input | 1 | Active-low enable for the input shift register |
| load_en_n | input | 1 | Active-low enable for the output latch |
| clr_n | input | 1 | Active-low asynchronous clear of both stages |
| sdout | output | 1 | Cascade output: bit 15 of the input register |
| dac_code | output | CODE_W | Straight-binary code driving the converter switches |

## Verification
The hardest states to reach are the ones that span two blocks, or that happen while a clear is active. The bench drives a second instance from the cascade output, so a 32-pulse stream must land the right word in each latch. A wrong `sdout` timing by a single bit would show up there. A clear is also pulsed in the middle of a word with a full serial-clock pulse inside it, so the ignored edge and the restart from zero are both observed at the ports. Reset is released with the serial clock already high and both enables low. This tests that the edge detector does not invent a pulse.

// File: rtl/ser_dac_pkg.sv
package ser_dac_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'b00,
    OP_SHIFT = 2'b01,
    OP_LOAD  = 2'b10,
    OP_THRU  = 2'b11
  } op_e;

  // Enables are active low; both low selects the pass-through mode
  function automatic op_e decode_op(input logic shift_n, input logic load_n);
    op_e r;
    unique case ({load_n, shift_n})
      2'b11:   r = OP_HOLD;
      2'b10:   r = OP_SHIFT;
      2'b01:   r = OP_LOAD;
      default: r = OP_THRU;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sdac_rst_sync.sv
module sdac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/sdac_in_sync.sv
module sdac_in_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic [W-1:0] src;
    logic [W-1:0] r;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_rest
      assign src = g_stg[g-1].r;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= RST_VAL;
      else        r <= src;
    end
  end

  assign q = g_stg[STAGES-1].r;
endmodule

// File: rtl/sdac_shift_reg.sv
module sdac_shift_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_go,
  input  logic         din,
  output logic [W-1:0] q,
  output logic [W-1:0] q_shifted
);
  logic [W-1:0] q_d;

  always_comb begin
    q_shifted = {q[W-2:0], din};
    q_d       = shift_go ? q_shifted : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/sdac_out_latch.sv
module sdac_out_latch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_go,
  input  logic         thru_go,
  input  logic [W-1:0] held_word,
  input  logic [W-1:0] next_word,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = load_go | thru_go;
    q_d  = thru_go ? next_word : held_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/ser_dac_front.sv
module ser_dac_front #(
  parameter int CODE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdin,
  input  logic              shift_en_n,
  input  logic              load_en_n,
  input  logic              clr_n,
  output logic              sdout,
  output logic [CODE_W-1:0] dac_code
);
  import ser_dac_pkg::*;

  localparam int         IN_W     = 4;
  // sclk, shift enable, load enable idle high; data idles low
  localparam logic [IN_W-1:0] IN_IDLE = 4'b1110;

  logic              sys_rst_n;
  logic              dat_rst_n;
  logic              dat_arst_n;
  logic [IN_W-1:0]   raw_in;
  logic [IN_W-1:0]   syn_in;
  logic              sclk_s;
  logic              shen_s;
  logic              lden_s;
  logic              sdin_s;
  logic              sclk_q;
  logic              sclk_rise;
  op_e               op;
  logic              shift_go;
  logic              load_go;
  logic              thru_go;
  logic [CODE_W-1:0] shreg;
  logic [CODE_W-1:0] shreg_next;

  assign dat_arst_n = rst_n & clr_n;

  sdac_rst_sync #(.STAGES(SYNC_STAGES)) u_sys_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(sys_rst_n)
  );

  sdac_rst_sync #(.STAGES(SYNC_STAGES)) u_dat_rst (
    .clk(clk), .arst_n(dat_arst_n), .srst_n(dat_rst_n)
  );

  assign raw_in = {sclk, shift_en_n, load_en_n, sdin};

  sdac_in_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(IN_IDLE)) u_in_sync (
    .clk(clk), .rst_n(sys_rst_n), .d(raw_in), .q(syn_in)
  );

  assign {sclk_s, shen_s, lden_s, sdin_s} = syn_in;

  // Edge history starts high so a level already high is not an edge
  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) sclk_q <= 1'b1;
    else            sclk_q <= sclk_s;
  end

  always_comb begin
    sclk_rise = sclk_s & ~sclk_q;
    op        = decode_op(shen_s, lden_s);
    shift_go  = sclk_rise & ((op == OP_SHIFT) | (op == OP_THRU));
    load_go   = sclk_rise & (op == OP_LOAD);
    thru_go   = sclk_rise & (op == OP_THRU);
  end

  sdac_shift_reg #(.W(CODE_W)) u_shift (
    .clk(clk), .rst_n(dat_rst_n), .shift_go(shift_go), .din(sdin_s),
    .q(shreg), .q_shifted(shreg_next)
  );

  sdac_out_latch #(.W(CODE_W)) u_latch (
    .clk(clk), .rst_n(dat_rst_n), .load_go(load_go), .thru_go(thru_go),
    .held_word(shreg), .next_word(shreg_next), .q(dac_code)
  );

  assign sdout = shreg[CODE_W-1];
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
  parameter int CODE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr_n,
  input logic              dat_rst_n,
  input logic              sclk_rise,
  input ser_dac_pkg::op_e  op,
  input logic              sdin_s,
  input logic [CODE_W-1:0] shreg,
  input logic              sdout,
  input logic [CODE_W-1:0] dac_code
);
  import ser_dac_pkg::*;

  // R2
  shift_only_chk: assert property (@(posedge clk) disable iff (!dat_rst_n)
    (sclk_rise && op == OP_SHIFT) |=>
      (shreg == {$past(shreg[CODE_W-2:0]), $past(sdin_s)}) && $stable(dac_code));

  // R3
  load_copy_chk: assert property (@(posedge clk) disable iff (!dat_rst_n)
    (sclk_rise && op == OP_LOAD) |=> (dac_code == $past(shreg)) && $stable(shreg));

  // R4
  thru_follow_chk: assert property (@(posedge clk) disable iff (!dat_rst_n)
    (sclk_rise && op == OP_THRU) |=> dac_code == shreg);

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!dat_rst_n)
    (!sclk_rise || op == OP_HOLD) |=> $stable(shreg) && $stable(dac_code));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> (dac_code == '0) && (shreg == '0) && !sdout);

  // R7
  sdout_edge_chk: assert property (@(posedge clk) disable iff (!dat_rst_n)
    !$stable(sdout) |-> $past(sclk_rise) && ($past(op) inside {OP_SHIFT, OP_THRU}));
endmodule

bind ser_dac_front sdac_front_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .dat_rst_n(dat_rst_n),
  .sclk_rise(sclk_rise), .op(op), .sdin_s(sdin_s), .shreg(shreg),
  .sdout(sdout), .dac_code(dac_code)
);

// File: tb/sim_ser_dac_front.sv
module sim_ser_dac_front;
  logic clk = 1'b0;
  logic rst_n, sclk, sdin, shift_en_n, load_en_n, clr_n;
  logic sdout0, sdout1;
  logic [15:0] code0, code1;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] m0_sh, m0_lat, m1_sh, m1_lat;

  always #2 clk = ~clk;

  ser_dac_front u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdin),
    .shift_en_n(shift_en_n), .load_en_n(load_en_n), .clr_n(clr_n),
    .sdout(sdout0), .dac_code(code0)
  );

  ser_dac_front u1 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdin(sdout0),
    .shift_en_n(shift_en_n), .load_en_n(load_en_n), .clr_n(clr_n),
    .sdout(sdout1), .dac_code(code1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " code"}, {16'h0, code0}, {16'h0, m0_lat});
    chk("R7 sdout", {31'h0, sdout0}, {31'h0, m0_sh[15]});
    chk("R7 cascade code", {16'h0, code1}, {16'h0, m1_lat});
    chk("R7 cascade sdout", {31'h0, sdout1}, {31'h0, m1_sh[15]});
  endtask

  // One serial clock pulse with the given enables and data bit
  task automatic pulse(input logic sh_n, input logic ld_n, input logic d);
    logic [15:0] n0, n1;
    @(negedge clk);
    shift_en_n = sh_n; load_en_n = ld_n; sdin = d;
    repeat (2) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sclk = 1'b0;
    repeat (3) @(negedge clk);
    if (clr_n) begin
      if (!sh_n) begin
        n0 = {m0_sh[14:0], d};
        n1 = {m1_sh[14:0], m0_sh[15]};
        if (!ld_n) begin m0_lat = n0; m1_lat = n1; end
        m0_sh = n0; m1_sh = n1;
      end else if (!ld_n) begin
        m0_lat = m0_sh; m1_lat = m1_sh;
      end
    end
  endtask

  task automatic send_word(input logic [15:0] w, input logic thru);
    for (int b = 15; b >= 0; b--) begin
      pulse(1'b0, thru ? 1'b0 : 1'b1, w[b]);
      chk_all(thru ? "R4" : "R2");
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m0_sh = '0; m0_lat = '0; m1_sh = '0; m1_lat = '0;
    // R9: reset released with sclk already high and both enables active
    rst_n = 1'b0; clr_n = 1'b1; sclk = 1'b1; sdin = 1'b1;
    shift_en_n = 1'b0; load_en_n = 1'b0;
    repeat (8) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk_all("R9");
    sclk = 1'b0; shift_en_n = 1'b1; load_en_n = 1'b1; sdin = 1'b0;
    repeat (4) @(negedge clk);
    chk_all("R9");

    // R1 R2 R3 R8: sweep of words, shift then latch
    for (int w = 0; w < 20; w++) begin
      logic [15:0] word;
      case (w)
        0: word = 16'h0000;
        1: word = 16'h8000;
        2: word = 16'hFFFF;
        3: word = 16'h7FFF;
        4: word = 16'h0001;
        default: word = 16'((w * 40503) ^ (w << 5));
      endcase
      send_word(word, 1'b0);
      pulse(1'b1, 1'b0, 1'b0);
      chk_all("R3");
      chk("R1 R8 word", {16'h0, code0}, {16'h0, word});
    end

    // R5: pulses with both enables high change nothing
    for (int k = 0; k < 4; k++) begin
      pulse(1'b1, 1'b1, k[0]);
      chk_all("R5");
    end
    // R5: enables wiggle without sclk
    @(negedge clk); shift_en_n = 1'b0; load_en_n = 1'b0; sdin = 1'b1;
    repeat (6) @(negedge clk);
    shift_en_n = 1'b1; load_en_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R5");

    // R4: two-wire mode, every bit visible
    send_word(16'hA5C3, 1'b1);
    send_word(16'h0FF0, 1'b1);

    // R6: clear mid-word with a pulse inside it
    send_word(16'h1234, 1'b0);
    for (int b = 0; b < 5; b++) pulse(1'b0, 1'b1, 1'b1);
    chk_all("R2");
    @(negedge clk);
    clr_n = 1'b0;
    #1;
    chk("R6 code", {16'h0, code0}, 32'h0);
    chk("R6 sdout", {31'h0, sdout0}, 32'h0);
    chk("R6 cascade", {16'h0, code1}, 32'h0);
    m0_sh = '0; m0_lat = '0; m1_sh = '0; m1_lat = '0;
    pulse(1'b0, 1'b0, 1'b1);
    chk_all("R6");
    @(negedge clk);
    clr_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_all("R6");

    // R7: cascade of two words through the chain
    send_word(16'hBEEF, 1'b0);
    send_word(16'h4321, 1'b0);
    pulse(1'b1, 1'b0, 1'b0);
    chk_all("R7");
    chk("R7 upstream word", {16'h0, code0}, 32'h4321);
    chk("R7 downstream word", {16'h0, code1}, 32'hBEEF);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule